// File: doc/BRIEF.md
# Cache write-allocate decision unit

This block sits beside a write-back data cache and settles, for every write that misses, whether the write becomes a line allocation or a single write on the bus. An allocation replaces the single non-burst bus write with a 32-byte burst read that brings the whole line in. Page tables are not consulted. The unit infers that the target is cacheable when any one of four indicators is true:

- the write falls in the same 4 KB page as the most recent line fill;
- the lookup reports a sector tag hit while the addressed line in that sector is invalid;
- the address lies below a programmable limit counted in 4 MB units;
- an enabled fixed 1 MB window contains the address.

The unit keeps the page of the most recent fill in a register that has a valid flag. The decision is registered one cycle after the write-miss strobe. A burst request that has been raised stays up until the bus acknowledges it. The tag and data arrays, the bus unit and replacement are outside this block. The cache is seen only through its lookup results.

Top module: `wr_alloc_decider`

## Requirements
- R1: While reset is low, and in the first cycle after it, `alloc_vld`, `alloc`, `burst_req` and `page_vld` are all 0.
- R2: A cycle with `fill_vld` high loads `fill_addr[31:12]` into `page_q` and sets `page_vld` at the next clock edge. A later fill from another page replaces the held page.
- R3: A write miss whose address bits [31:12] equal `page_q` while `page_vld` is 1 gives `alloc_vld`=1 and `alloc`=1 in the cycle after the strobe.
- R4: Before the first fill, no page match can occur, even for a write to page 0.
- R5: A write miss with `sect_hit`=1 and `line_valid`=0 allocates. With `line_valid`=1 this indicator is false.
- R6: A write miss allocates when `wr_addr[31:22]` is less than `cfg_limit`. An equal or greater value does not allocate. `cfg_limit`=0 disables this indicator.
- R7: With `cfg_special_en`=1, a write miss in the window 0x00F0_0000 to 0x00FF_FFFF (bits [31:20] equal to 15) allocates. With the enable low, that window has no effect.
- R8: A write miss with no indicator true gives `alloc_vld`=1 and `alloc`=0, and does not raise `burst_req`.
- R9: An allocation raises `burst_req` together with `alloc_vld`. It stays high while `bus_ack` is 0 and drops at the edge that samples `bus_ack`=1.
- R10: `alloc_vld` is a single-cycle pulse that appears only in the cycle after `wr_miss` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_vld | input | 1 | A cache line fill happens this cycle |
| fill_addr | input | 32 | Address of the filled line |
| wr_miss | input | 1 | Pending write missed the cache this cycle |
| wr_addr | input | 32 | Address of the pending write |
| sect_hit | input | 1 | Sector tag matched for `wr_addr` |
| line_valid | input | 1 | Valid bit of the addressed line in the matching sector |
| cfg_limit | input | 10 | Allocate limit in 4 MB units; 0 disables |
| cfg_special_en | input | 1 | Enables allocation in the fixed 1 MB window |
| bus_ack | input | 1 | Bus accepted the burst request |
| alloc_vld | output | 1 | Decision valid, one-cycle pulse |
| alloc | output | 1 | 1 = allocate, 0 = single bus write |
| burst_req | output | 1 | 32-byte burst read request, held until acknowledged |
| page_vld | output | 1 | `page_q` holds a fill page |
| page_q | output | 20 | Page number of the last line fill |

## Verification
Writes are aimed so that exactly one indicator is true at a time. This shows which path produced an allocation:

- an address in the page of the last fill, then in the next page, then in the old page again after a fill from another page has replaced it;
- sector results with the line valid and with it invalid;
- addresses one 4 MB unit below the limit and exactly at it, with the limit then set to zero;
- addresses inside the 1 MB window, and just under and just over it, with the enable high and low.

A write to page 0 before any fill separates the valid flag from a reset value of zero in `page_q`. Idle cycles with a pending burst request, followed by an acknowledge, show how long the request is held.

// File: rtl/wa_pkg.sv
// Shared types for the write-allocate decision unit.
// Assumes nothing beyond a flat 32-bit or wider physical address.
package wa_pkg;
    // One flag per cacheability indicator, ORed into the final decision.
    typedef struct packed {
        logic page_match;
        logic sector_gap;
        logic below_limit;
        logic special_win;
    } wa_hint_t;
endpackage

// File: rtl/wa_page_tracker.sv
// Holds the page number of the most recent cache line fill, with a valid flag.
// Assumes fills and writes may share a cycle; the compare then sees the old page.
module wa_page_tracker #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_vld,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              match,
    output logic              page_vld,
    output logic [PAGE_W-1:0] page_q
);
    logic [PAGE_W-1:0] fill_page;
    logic              new_page;

    assign fill_page = fill_addr[ADDR_W-1:PAGE_SHIFT];
    // The register is written only when the page actually changes.
    assign new_page  = fill_vld && (!page_vld || (fill_page != page_q));

    // Load the page register on a fill from a different page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_vld <= 1'b0;
            page_q   <= '0;
        end else if (new_page) begin
            page_vld <= 1'b1;
            page_q   <= fill_page;
        end
    end

    // Compare the pending write's page against the held page.
    always_comb begin
        match = page_vld && (wr_addr[ADDR_W-1:PAGE_SHIFT] == page_q);
    end
endmodule

// File: rtl/wa_region_check.sv
// Evaluates the programmable limit and the fixed 1 MB window for a write.
// Assumes the limit counts in 4 MB units and that a limit of zero disables it.
module wa_region_check #(
    parameter int ADDR_W      = 32,
    parameter int LIMIT_SHIFT = 22,
    parameter int WIN_SHIFT   = 20,
    parameter int WIN_INDEX   = 15,
    localparam int LIMIT_W    = ADDR_W - LIMIT_SHIFT,
    localparam int WIN_W      = ADDR_W - WIN_SHIFT
) (
    input  logic               cfg_special_en,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic [ADDR_W-1:0]  wr_addr,
    output logic               below_limit,
    output logic               in_window
);
    // Unsigned compare; a zero limit can never be exceeded from below.
    always_comb begin
        below_limit = wr_addr[ADDR_W-1:LIMIT_SHIFT] < cfg_limit;
    end

    // Fixed window match gated by its enable.
    always_comb begin
        in_window = cfg_special_en &&
                    (wr_addr[ADDR_W-1:WIN_SHIFT] == WIN_W'(WIN_INDEX));
    end
endmodule

// File: rtl/wa_decision_reg.sv
// Registers the allocate decision and holds the burst request until acknowledged.
// Assumes a new allocation and an acknowledge in one cycle keep the request up.
module wa_decision_reg
    import wa_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_miss,
    input  wa_hint_t hint,
    input  logic     bus_ack,
    output logic     alloc_vld,
    output logic     alloc,
    output logic     burst_req
);
    logic take;

    // Any one indicator is enough to allocate.
    assign take = hint.page_match | hint.sector_gap | hint.below_limit | hint.special_win;

    // Capture the decision one cycle after the write-miss strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_vld <= 1'b0;
            alloc     <= 1'b0;
        end else begin
            alloc_vld <= wr_miss;
            if (wr_miss) alloc <= take;
        end
    end

    // Raise the burst read on allocation, drop it on bus acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                burst_req <= 1'b0;
        else if (wr_miss && take)  burst_req <= 1'b1;
        else if (bus_ack)          burst_req <= 1'b0;
    end
endmodule

// File: rtl/wr_alloc_decider.sv
// Top of the write-allocate decision unit: gathers the four cacheability
// indicators for a missing write and registers the allocate decision.
// Assumes sect_hit/line_valid are valid in the same cycle as wr_miss.
module wr_alloc_decider
    import wa_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int LIMIT_SHIFT = 22,
    parameter int WIN_SHIFT   = 20,
    parameter int WIN_INDEX   = 15,
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT,
    localparam int LIMIT_W    = ADDR_W - LIMIT_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_vld,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic               wr_miss,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               sect_hit,
    input  logic               line_valid,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic               cfg_special_en,
    input  logic               bus_ack,
    output logic               alloc_vld,
    output logic               alloc,
    output logic               burst_req,
    output logic               page_vld,
    output logic [PAGE_W-1:0]  page_q
);
    wa_hint_t hint;
    logic     pg_match, lim_hit, win_hit;

    wa_page_tracker #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_vld (fill_vld),
        .fill_addr(fill_addr),
        .wr_addr  (wr_addr),
        .match    (pg_match),
        .page_vld (page_vld),
        .page_q   (page_q)
    );

    wa_region_check #(
        .ADDR_W(ADDR_W), .LIMIT_SHIFT(LIMIT_SHIFT),
        .WIN_SHIFT(WIN_SHIFT), .WIN_INDEX(WIN_INDEX)
    ) u_region (
        .cfg_special_en(cfg_special_en),
        .cfg_limit     (cfg_limit),
        .wr_addr       (wr_addr),
        .below_limit   (lim_hit),
        .in_window     (win_hit)
    );

    // Pack the indicators; a sector hit on an invalid line marks the page cacheable.
    always_comb begin
        hint.page_match  = pg_match;
        hint.sector_gap  = sect_hit && !line_valid;
        hint.below_limit = lim_hit;
        hint.special_win = win_hit;
    end

    wa_decision_reg u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_miss  (wr_miss),
        .hint     (hint),
        .bus_ack  (bus_ack),
        .alloc_vld(alloc_vld),
        .alloc    (alloc),
        .burst_req(burst_req)
    );
endmodule

// File: rtl/wr_alloc_chk.sv
// Assertion checker for wr_alloc_decider, attached by bind below.
// Assumes the default 32-bit address and 4 KB pages.
module wr_alloc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fill_vld,
    input logic [31:0] fill_addr,
    input logic        wr_miss,
    input logic        bus_ack,
    input logic        alloc_vld,
    input logic        alloc,
    input logic        burst_req,
    input logic        page_vld,
    input logic [19:0] page_q
);
    // R1: outputs cleared by reset
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!alloc_vld && !alloc && !burst_req && !page_vld));

    // R2: fill loads the page register
    a_r2_fill_load: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> (page_vld && page_q == $past(fill_addr[31:12])));

    // R10: decision pulse follows the strobe
    a_r10_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_miss |=> alloc_vld);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_miss |=> !alloc_vld);

    // R8: burst request only rises with an allocate decision
    a_r8_rise_needs_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_req) |-> (alloc_vld && alloc));

    // R9: request held until acknowledged, dropped after it
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_req && !bus_ack) |=> burst_req);
    a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_req && bus_ack && !wr_miss) |=> !burst_req);
endmodule

bind wr_alloc_decider wr_alloc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_vld (fill_vld),
    .fill_addr(fill_addr),
    .wr_miss  (wr_miss),
    .bus_ack  (bus_ack),
    .alloc_vld(alloc_vld),
    .alloc    (alloc),
    .burst_req(burst_req),
    .page_vld (page_vld),
    .page_q   (page_q)
);

// File: tb/tb_wr_alloc_decider.sv
// Directed bench for wr_alloc_decider: one task per scenario.
module tb_wr_alloc_decider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_vld = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        wr_miss = 1'b0;
    logic [31:0] wr_addr = '0;
    logic        sect_hit = 1'b0;
    logic        line_valid = 1'b0;
    logic [9:0]  cfg_limit = '0;
    logic        cfg_special_en = 1'b0;
    logic        bus_ack = 1'b0;
    logic        alloc_vld, alloc, burst_req, page_vld;
    logic [19:0] page_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    wr_alloc_decider dut (
        .clk(clk), .rst_n(rst_n), .fill_vld(fill_vld), .fill_addr(fill_addr),
        .wr_miss(wr_miss), .wr_addr(wr_addr), .sect_hit(sect_hit),
        .line_valid(line_valid), .cfg_limit(cfg_limit),
        .cfg_special_en(cfg_special_en), .bus_ack(bus_ack),
        .alloc_vld(alloc_vld), .alloc(alloc), .burst_req(burst_req),
        .page_vld(page_vld), .page_q(page_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one write miss; check the decision and the burst request at the next negedge.
    task automatic do_write(input string req, input logic [31:0] a, input logic sh,
                            input logic lv, input logic exp_alloc);
        @(negedge clk);
        wr_miss = 1'b1; wr_addr = a; sect_hit = sh; line_valid = lv;
        @(negedge clk);
        wr_miss = 1'b0; sect_hit = 1'b0; line_valid = 1'b0;
        check({req, " alloc_vld"}, {31'd0, alloc_vld}, 32'd1);
        check({req, " alloc"}, {31'd0, alloc}, {31'd0, exp_alloc});
        check({req, " burst_req"}, {31'd0, burst_req}, {31'd0, exp_alloc});
        if (exp_alloc) begin
            bus_ack = 1'b1;
            @(negedge clk);
            bus_ack = 1'b0;
            check({req, " R9 burst drop"}, {31'd0, burst_req}, 32'd0);
        end
    endtask

    task automatic do_fill(input logic [31:0] a);
        @(negedge clk);
        fill_vld = 1'b1; fill_addr = a;
        @(negedge clk);
        fill_vld = 1'b0;
        check("R2 page_vld", {31'd0, page_vld}, 32'd1);
        check("R2 page_q", {12'd0, page_q}, {12'd0, a[31:12]});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 alloc_vld", {31'd0, alloc_vld}, 32'd0);
        check("R1 alloc", {31'd0, alloc}, 32'd0);
        check("R1 burst_req", {31'd0, burst_req}, 32'd0);
        check("R1 page_vld", {31'd0, page_vld}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {30'd0, alloc_vld, burst_req}, 32'd0);
    endtask

    task automatic t_no_fill_yet;
        do_write("R4 page0 before fill", 32'h0000_0100, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_page_match;
        do_fill(32'h1234_5040);
        do_write("R3 same page", 32'h1234_5F00, 1'b0, 1'b0, 1'b1);
        do_write("R8 next page", 32'h1234_6000, 1'b0, 1'b0, 1'b0);
        do_fill(32'h0ABC_D000);
        do_write("R2 old page replaced", 32'h1234_5000, 1'b0, 1'b0, 1'b0);
        do_write("R3 new page", 32'h0ABC_D7FC, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_sector;
        do_write("R5 sector gap", 32'h5000_0000, 1'b1, 1'b0, 1'b1);
        do_write("R5 line valid", 32'h5000_0000, 1'b1, 1'b1, 1'b0);
        do_write("R8 no sector hit", 32'h5000_0020, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_limit;
        cfg_limit = 10'd4;
        do_write("R6 below limit", 32'h00FF_FFFC, 1'b0, 1'b0, 1'b1);
        do_write("R6 at limit", 32'h0100_0000, 1'b0, 1'b0, 1'b0);
        cfg_limit = 10'd0;
        do_write("R6 limit zero", 32'h0000_1000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_window;
        cfg_special_en = 1'b1;
        do_write("R7 window start", 32'h00F0_0000, 1'b0, 1'b0, 1'b1);
        do_write("R7 above window", 32'h0100_0000, 1'b0, 1'b0, 1'b0);
        do_write("R7 below window", 32'h00EF_FFFC, 1'b0, 1'b0, 1'b0);
        cfg_special_en = 1'b0;
        do_write("R7 window disabled", 32'h00F8_0000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hold;
        // R9: request held over idle cycles without acknowledge
        @(negedge clk);
        wr_miss = 1'b1; wr_addr = 32'h0ABC_D000;
        @(negedge clk);
        wr_miss = 1'b0;
        check("R9 raised", {31'd0, burst_req}, 32'd1);
        @(negedge clk);
        check("R10 single pulse", {31'd0, alloc_vld}, 32'd0);
        repeat (3) @(negedge clk);
        check("R9 held", {31'd0, burst_req}, 32'd1);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check("R9 dropped", {31'd0, burst_req}, 32'd0);
        check("R10 idle", {31'd0, alloc_vld}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_no_fill_yet;
        t_page_match;
        t_sector;
        t_limit;
        t_window;
        t_hold;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule